// File: doc/BRIEF.md
# Card Response Capture Register Bank

This block collects the response that a memory card returns after a command. The response arrives one bit per card bus clock, most significant payload bit first. The block packs the bits into four 32-bit response words that software can read but not write. The command state machine tells the block when a response begins and whether it is short or long. It can also cut a response off early. Start-bit detection, CRC checks and command index checks are done elsewhere.

A short response carries 32 status bits, which land in the first word; the other three words read as zero. A long response carries 127 payload bits. These are left-justified across all four words, so the lowest bit of the last word is always zero. A single-cycle done pulse marks a complete capture. The words then stay unchanged until the next start, so software can read them through the word outputs or through the addressed read port.

Top module: `resp_capture_bank`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all four words and done.
- R2: cap_start clears all four words at the next edge, latches cap_long and begins a capture. A bit offered in the same cycle as the start is dropped.
- R3: During a capture, a bit is accepted only at an edge where card_ce and rsp_valid are both high. The bits shift in MSB first, so after k accepted bits they sit right-justified in the payload field.
- R4: A short capture (cap_long=0) takes 32 bits. The first bit received ends up in resp_w0[31] and the last in resp_w0[0]. resp_w1, resp_w2 and resp_w3 read zero.
- R5: A long capture (cap_long=1) takes 127 bits. The first bit ends up in resp_w0[31] and the last in resp_w3[1]. resp_w3[0] always reads 0.
- R6: done is high for exactly one cycle, the cycle after the edge that accepts the final bit. Bits offered after that edge are ignored.
- R7: cap_end during a capture stops it at that edge. done stays low, a bit offered in the same cycle is dropped, and the bits already received are kept.
- R8: Outside a capture, and with no start, all four words keep their values.
- R9: rd_data shows resp_w0, resp_w1, resp_w2 or resp_w3 combinationally for rd_addr equal to 0, 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| card_ce | input | 1 | Card bus clock enable |
| rsp_bit | input | 1 | Serial response bit |
| rsp_valid | input | 1 | Response bit valid strobe |
| cap_start | input | 1 | Begin a new capture |
| cap_long | input | 1 | Capture type at start: 1 long, 0 short |
| cap_end | input | 1 | Terminate the capture in progress |
| rd_addr | input | 2 | Read port word select |
| rd_data | output | 32 | Selected response word |
| resp_w0 | output | 32 | Response word 0 (most significant) |
| resp_w1 | output | 32 | Response word 1 |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3, bit 0 held at 0 |
| done | output | 1 | One-cycle capture complete pulse |

## Verification
A single 1 is walked through every payload position of both the short and the long response. This shows that each received bit lands in exactly one place in the words, and it would reveal an off-by-one or reversed packing. All-ones, alternating and counting payloads, some sent with stalled enables and idle strobes, separate correct bit gating from bits taken on cycles where card_ce or rsp_valid is low. Further tests cover the extra bit offered after done, a cut-off capture and a start given on top of a valid bit. These show that the block ignores input outside a capture and that the words hold their values.

// File: rtl/resp_capture_bank.sv
module resp_capture_bank #(
  parameter int WORD_W     = 32,
  parameter int SHORT_BITS = 32,
  parameter int LONG_BITS  = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              card_ce,
  input  logic              rsp_bit,
  input  logic              rsp_valid,
  input  logic              cap_start,
  input  logic              cap_long,
  input  logic              cap_end,
  input  logic [1:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] resp_w0,
  output logic [WORD_W-1:0] resp_w1,
  output logic [WORD_W-1:0] resp_w2,
  output logic [WORD_W-1:0] resp_w3,
  output logic              done
);
  localparam int TOTAL = 4 * WORD_W;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int LLO   = TOTAL - LONG_BITS;
  localparam int SLO   = TOTAL - SHORT_BITS;

  logic [TOTAL-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic             busy, long_q;

  wire [CNT_W-1:0] need = long_q ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);
  wire             take = busy & card_ce & rsp_valid;
  wire             last = take && (cnt == need - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      long_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cap_start) begin
        sr     <= '0;
        cnt    <= '0;
        busy   <= 1'b1;
        long_q <= cap_long;
      end else if (busy && cap_end) begin
        busy <= 1'b0;
      end else if (take) begin
        cnt <= cnt + CNT_W'(1);
        if (long_q)
          sr[TOTAL-1:LLO] <= {sr[TOTAL-2:LLO], rsp_bit};
        else
          sr[TOTAL-1:SLO] <= {sr[TOTAL-2:SLO], rsp_bit};
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign resp_w0 = sr[4*WORD_W-1:3*WORD_W];
  assign resp_w1 = sr[3*WORD_W-1:2*WORD_W];
  assign resp_w2 = sr[2*WORD_W-1:WORD_W];
  assign resp_w3 = sr[WORD_W-1:0];

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = resp_w0;
      2'd1:    rd_data = resp_w1;
      2'd2:    rd_data = resp_w2;
      default: rd_data = resp_w3;
    endcase
  end
endmodule

module resp_capture_checks #(parameter int WORD_W = 32) (
  input logic              clk,
  input logic              rst,
  input logic              cap_start,
  input logic              cap_end,
  input logic              busy,
  input logic              long_q,
  input logic              done,
  input logic [WORD_W-1:0] resp_w0,
  input logic [WORD_W-1:0] resp_w1,
  input logic [WORD_W-1:0] resp_w2,
  input logic [WORD_W-1:0] resp_w3
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cap_start |=> (resp_w0 == '0 && resp_w1 == '0 && resp_w2 == '0 && resp_w3 == '0)); // R2
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !long_q |-> (resp_w1 == '0 && resp_w2 == '0 && resp_w3 == '0)); // R4
  AST_LAST_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    resp_w3[0] == 1'b0); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6
  AST_END_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (busy && cap_end && !cap_start) |=> (!busy && !done)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cap_start) |=> ($stable(resp_w0) && $stable(resp_w1) &&
                               $stable(resp_w2) && $stable(resp_w3))); // R8
endmodule

bind resp_capture_bank resp_capture_checks #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst(rst), .cap_start(cap_start), .cap_end(cap_end),
  .busy(busy), .long_q(long_q), .done(done),
  .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3)
);

// File: tb/test_resp_capture_bank.sv
`timescale 1ns/1ps
module test_resp_capture_bank;
  logic clk = 1'b0, rst = 1'b1;
  logic card_ce = 1'b0, rsp_bit = 1'b0, rsp_valid = 1'b0;
  logic cap_start = 1'b0, cap_long = 1'b0, cap_end = 1'b0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data, resp_w0, resp_w1, resp_w2, resp_w3;
  logic        done;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  resp_capture_bank i_resp_capture_bank (
    .clk(clk), .rst(rst), .card_ce(card_ce), .rsp_bit(rsp_bit),
    .rsp_valid(rsp_valid), .cap_start(cap_start), .cap_long(cap_long),
    .cap_end(cap_end), .rd_addr(rd_addr), .rd_data(rd_data),
    .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2),
    .resp_w3(resp_w3), .done(done)
  );

  function automatic logic [127:0] words();
    return {resp_w0, resp_w1, resp_w2, resp_w3};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_read(logic [127:0] exp);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      chk("R9 read port", 128'(rd_data), 128'(exp[127-32*a -: 32]));
    end
  endtask

  task automatic capture(bit lng, logic [126:0] pay, bit gaps);
    int n;
    logic [127:0] exp;
    n   = lng ? 127 : 32;
    exp = lng ? {pay, 1'b0} : {pay[31:0], 96'b0};
    @(negedge clk);
    cap_start = 1'b1; cap_long = lng; rsp_valid = 1'b1; rsp_bit = 1'b1; card_ce = 1'b1;
    @(negedge clk);
    cap_start = 1'b0; cap_long = 1'b0;
    chk("R2 start clears", words(), 128'b0);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        rsp_bit = ~pay[n-1-i]; rsp_valid = 1'b1; card_ce = 1'b0;
        @(negedge clk);
        rsp_valid = 1'b0; card_ce = 1'b1;
        @(negedge clk);
      end
      rsp_bit = pay[n-1-i]; rsp_valid = 1'b1; card_ce = 1'b1;
      @(negedge clk);
      if (i < n - 1 && done !== 1'b0) chk("R6 early done", 128'(done), 128'(0));
    end
    rsp_bit = 1'b1; rsp_valid = 1'b1;
    chk(lng ? "R5 long packing" : "R4 short packing", words(), exp);
    chk("R6 done pulse", 128'(done), 128'(1));
    @(negedge clk);
    rsp_valid = 1'b0;
    chk("R6 done single", 128'(done), 128'(0));
    chk("R8 hold after done", words(), exp);
    chk_read(exp);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset words", words(), 128'b0);
    chk("R1 reset done", 128'(done), 128'(0));

    for (int k = 0; k < 32; k++) capture(1'b0, 127'(1) << k, 1'b0);
    for (int k = 0; k < 127; k++) capture(1'b1, 127'(1) << k, 1'b0);
    capture(1'b0, {95'b0, 32'hFFFF_FFFF}, 1'b1);
    capture(1'b0, {95'b0, 32'hA5C3_0F96}, 1'b1);
    capture(1'b1, {127{1'b1}}, 1'b1);
    capture(1'b1, {32'h0123_4567, 32'h89AB_CDEF, 32'h5555_AAAA, 31'h3C3C_3C3C}, 1'b1);

    // R3 gating and R7 abort: 5 bits 1,0,1,1,0 then cap_end with a bit
    @(negedge clk);
    cap_start = 1'b1; cap_long = 1'b0;
    @(negedge clk);
    cap_start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      rsp_bit = (5'b10110 >> (4 - i)) & 1'b1; rsp_valid = 1'b1; card_ce = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_bit = 1'b1;
      @(negedge clk);
    end
    chk("R3 partial right-justified", words(), {32'h16, 96'b0});
    cap_end = 1'b1; rsp_valid = 1'b1; rsp_bit = 1'b1;
    @(negedge clk);
    cap_end = 1'b0;
    chk("R7 abort keeps bits", words(), {32'h16, 96'b0});
    chk("R7 abort no done", 128'(done), 128'(0));
    repeat (4) begin
      @(negedge clk);
      chk("R8 idle hold", words(), {32'h16, 96'b0});
    end
    rsp_valid = 1'b0;

    // R1 reset during capture
    @(negedge clk);
    cap_start = 1'b1; cap_long = 1'b1;
    @(negedge clk);
    cap_start = 1'b0; rsp_valid = 1'b1; rsp_bit = 1'b1;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; rsp_valid = 1'b0;
    chk("R1 reset mid capture", words(), 128'b0);
    chk("R1 reset done low", 128'(done), 128'(0));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule